// File: doc/BRIEF.md
# Two-Bit Mealy State Machine

This block is a small synchronous Mealy machine. It holds its state in two D-type register bits, called high bit A and low bit B, and reads one serial input bit each clock. Its single output bit depends on the present state and on the input in the same cycle. The next-state logic is the minimized sum-of-products form of a fixed four-state map. The state bits are brought out so that a neighbouring block or a bench can watch the machine step.

The four states are named by the pair (A,B):

- REST is 00.
- ARM is 01.
- HOLD is 10.
- LOCK is 11.

The transitions are as follows:

- REST stays put on a 0. It steps to ARM on a 1, and the output pulses high in that cycle.
- ARM falls to HOLD on a 0 and stays in ARM on a 1.
- HOLD stays put on a 0. It steps to LOCK on a 1, with the output high in that cycle.
- LOCK stays put on a 0 and wraps back to REST on a 1.

An active-high synchronous reset returns the machine to REST.

Top module: `mealy2_fsm`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state after that edge is REST (`st_hi`=0, `st_lo`=0), whatever the value of `din`.
- R2: The state pins show A on `st_hi` and B on `st_lo`. They change only at a rising clock edge, taking the next-state value computed from the state and `din` before that edge.
- R3: From REST, `din`=0 gives REST next, and `din`=1 gives ARM (01) next.
- R4: From ARM (01), `din`=0 gives HOLD (10) next, and `din`=1 keeps ARM.
- R5: From HOLD (10), `din`=0 keeps HOLD, and `din`=1 gives LOCK (11) next.
- R6: From LOCK (11), `din`=0 keeps LOCK, and `din`=1 gives REST (00) next.
- R7: `dout` is 1 exactly when B=0 and `din`=1 (REST or HOLD with input 1). It follows `din` combinationally within the same cycle, with no register delay.
- R8: While `rst` stays high for several cycles, the state stays REST on every cycle, and input pulses have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit |
| dout | output | 1 | Mealy output bit |
| st_hi | output | 1 | State bit A |
| st_lo | output | 1 | State bit B |

## Verification
The assertions assume that `din` and `rst` are stable around each rising edge and are never X or Z once reset has been applied. They compare the state after an edge with the state and input seen at that edge. The bench therefore changes inputs only on the falling edge and samples the outputs shortly after, well clear of the active edge. Random input streams are mixed with occasional reset pulses and directed walks through every state-input pair, so that every transition is taken both in and out of reset.

// File: rtl/mfsm_pkg.sv
package mfsm_pkg;
    localparam int STATE_BITS = 2;

    typedef enum logic [STATE_BITS-1:0] {
        ST_REST = 2'b00,
        ST_ARM  = 2'b01,
        ST_HOLD = 2'b10,
        ST_LOCK = 2'b11
    } st_e;
endpackage

// File: rtl/mfsm_next.sv
// Next-state logic. SOP_FORM picks the minimized gate equations or an
// equivalent state-case description; both yield the same map.
module mfsm_next #(
    parameter bit SOP_FORM = 1'b1
) (
    input  logic a,
    input  logic b,
    input  logic x,
    output logic da,
    output logic db
);
    import mfsm_pkg::*;

    generate
        if (SOP_FORM) begin : g_sop
            assign da = (a & ~b) | (b & ~x);
            assign db = (~a & x) | (~b & x) | (a & b & ~x);
        end else begin : g_case
            st_e cur;
            st_e nxt;
            assign cur = st_e'({a, b});
            always_comb begin
                unique case (cur)
                    ST_REST: nxt = x ? ST_ARM  : ST_REST;
                    ST_ARM:  nxt = x ? ST_ARM  : ST_HOLD;
                    ST_HOLD: nxt = x ? ST_LOCK : ST_HOLD;
                    ST_LOCK: nxt = x ? ST_REST : ST_LOCK;
                    default: nxt = ST_REST;
                endcase
            end
            assign da = nxt[1];
            assign db = nxt[0];
        end
    endgenerate
endmodule

// File: rtl/mfsm_out.sv
// Mealy output: high when the low state bit is clear and the input is set.
module mfsm_out (
    input  logic b,
    input  logic x,
    output logic y
);
    always_comb begin
        y = ~b & x;
    end
endmodule

// File: rtl/mfsm_state_reg.sv
// Two D-type state bits with synchronous reset to REST.
module mfsm_state_reg (
    input  logic             clk,
    input  logic             rst,
    input  mfsm_pkg::st_e    d,
    output mfsm_pkg::st_e    q
);
    import mfsm_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ST_REST;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mealy2_fsm.sv
module mealy2_fsm #(
    parameter bit SOP_FORM = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic st_hi,
    output logic st_lo
);
    import mfsm_pkg::*;

    st_e  state_q;
    st_e  state_d;
    logic da;
    logic db;

    mfsm_next #(.SOP_FORM(SOP_FORM)) u_next (
        .a  (state_q[1]),
        .b  (state_q[0]),
        .x  (din),
        .da (da),
        .db (db)
    );

    assign state_d = st_e'({da, db});

    mfsm_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (state_d),
        .q   (state_q)
    );

    mfsm_out u_out (
        .b (state_q[0]),
        .x (din),
        .y (dout)
    );

    assign st_hi = state_q[1];
    assign st_lo = state_q[0];
endmodule

// File: rtl/mealy2_fsm_chk.sv
module mealy2_fsm_chk (
    input logic clk,
    input logic rst,
    input logic din,
    input logic dout,
    input logic st_hi,
    input logic st_lo
);
    logic [1:0] st;
    assign st = {st_hi, st_lo};

    assert_reset_rest_R1: assert property (@(posedge clk)
        rst |=> (st == 2'b00));

    assert_rest_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b00 && !din) |=> (st == 2'b00));
    assert_rest_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b00 && din) |=> (st == 2'b01));

    assert_arm_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b01 && !din) |=> (st == 2'b10));
    assert_arm_stay_R4: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b01 && din) |=> (st == 2'b01));

    assert_hold_stay_R5: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b10 && !din) |=> (st == 2'b10));
    assert_hold_lock_R5: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b10 && din) |=> (st == 2'b11));

    assert_lock_stay_R6: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b11 && !din) |=> (st == 2'b11));
    assert_lock_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b11 && din) |=> (st == 2'b00));

    assert_out_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (st[1] == 1'b0 && st[0] == 1'b0 && din) |-> dout);
    assert_out_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (st == 2'b01 || st == 2'b11 || !din) |-> !dout);
endmodule

bind mealy2_fsm mealy2_fsm_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .din   (din),
    .dout  (dout),
    .st_hi (st_hi),
    .st_lo (st_lo)
);

// File: tb/mealy2_fsm_test.sv
`timescale 1ns/1ps
module mealy2_fsm_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic dout, st_hi, st_lo;

    int checks = 0;
    int errors = 0;
    logic [1:0] model = 2'b00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mealy2_fsm uut (
        .clk(clk), .rst(rst), .din(din),
        .dout(dout), .st_hi(st_hi), .st_lo(st_lo)
    );

    // Transition map from R3..R6.
    function automatic logic [1:0] exp_next(input logic [1:0] s, input logic x);
        case (s)
            2'b00: return x ? 2'b01 : 2'b00;
            2'b01: return x ? 2'b01 : 2'b10;
            2'b10: return x ? 2'b11 : 2'b10;
            default: return x ? 2'b00 : 2'b11;
        endcase
    endfunction

    // Output rule from R7.
    function automatic logic exp_out(input logic [1:0] s, input logic x);
        return (s == 2'b00 || s == 2'b10) && x;
    endfunction

    function automatic string req_of(input logic [1:0] s);
        case (s)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive on falling edge, check outputs, then take the rising edge.
    task automatic step(input logic r, input logic x, input string req);
        @(negedge clk);
        rst = r;
        din = x;
        #1;
        chk(req, {st_hi, st_lo}, model);               // R2 state held between edges
        chk("R7", {1'b0, dout}, {1'b0, exp_out(model, x)});
        @(posedge clk);
        model = r ? 2'b00 : exp_next(model, x);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R1 reset state.
        @(posedge clk);
        model = 2'b00;
        @(negedge clk);
        chk("R1", {st_hi, st_lo}, 2'b00);
        // R8: reset held with input toggling.
        for (int i = 0; i < 6; i++) step(1'b1, i[0], "R8");
        // Directed walk over every state/input pair.
        step(1'b0, 1'b0, "R3");   // REST stays
        step(1'b0, 1'b1, "R3");   // REST -> ARM
        step(1'b0, 1'b1, "R4");   // ARM stays
        step(1'b0, 1'b0, "R4");   // ARM -> HOLD
        step(1'b0, 1'b0, "R5");   // HOLD stays
        step(1'b0, 1'b1, "R5");   // HOLD -> LOCK
        step(1'b0, 1'b0, "R6");   // LOCK stays
        step(1'b0, 1'b1, "R6");   // LOCK -> REST
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b0, "R4");
        step(1'b0, 1'b1, "R5");   // now LOCK
        step(1'b1, 1'b1, "R6");   // R1: reset from LOCK with din=1
        step(1'b0, 1'b0, "R1");   // confirms REST after reset
        // Random stream with occasional reset.
        for (int i = 0; i < 2000; i++) begin
            logic r;
            logic x;
            r = ($urandom % 32) == 0;
            x = $urandom % 2;
            step(r, x, r ? "R1" : req_of(model));
        end
        @(negedge clk);
        chk("R2", {st_hi, st_lo}, model);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule